// File: doc/BRIEF.md
# Temperature-Scaled DRAM Refresh and Traffic Throttle Scheduler

This block paces refresh for one DRAM channel and gates how often user traffic may be accepted, both as a function of the die temperature it is given. A countdown derived from the clock frequency raises a refresh request once per nominal refresh period of 7.8 µs. That period is halved in the warm band and quartered in the hot band. The request stays up until the command scheduler acknowledges it. Refreshes that fall due before an acknowledge are queued in a small counter, and a flag reports when that counter cannot take another one.

The temperature bands have 2 °C of hysteresis on the way down. A new period takes effect only when the running countdown reloads. A second, independent path compares the temperature with a programmable limit. Above that limit a free-running 4-bit phase counter opens the accept-allow mask on N cycles of every 16, where N is the programmed ratio. The user interface qualifies its handshakes with that mask.

Top module: `refresh_throttle_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `ref_req` is 0, `ref_pending` is 0 and `ref_overflow` is 0.
- R2: With the temperature below 85 °C, refresh events occur exactly every NOM cycles, where NOM = CLK_MHZ × 7800 / 1000.
- R3: With the temperature in the warm band (entered at 85 °C or more), refresh events occur every floor(NOM/2) cycles.
- R4: With the temperature in the hot band (entered at 95 °C or more), refresh events occur every floor(NOM/4) cycles.
- R5: The hot band is left only when the temperature falls below 93 °C, and the warm band only when it falls below 83 °C. A fall from the hot band straight to below 83 °C returns to the nominal period.
- R6: A change of temperature band never alters a countdown already in progress. The new period applies from the next reload.
- R7: `ref_req` is high exactly while `ref_pending` is non-zero. Each cycle with `ref_ack` high and `ref_req` high removes one pending refresh. `ref_ack` while `ref_req` is low has no effect.
- R8: Unacknowledged refresh events increment `ref_pending`, which saturates at 8.
- R9: `ref_overflow` goes high when a refresh event arrives while 8 are already pending and no acknowledge is taken. It stays high until the next accepted acknowledge clears it.
- R10: When `temp_c` ≤ `thr_c`, `accept_allow` is 1 on every cycle, whatever `thr_ratio` holds.
- R11: When `temp_c` > `thr_c`, `accept_allow` is 1 on exactly `thr_ratio` cycles of any 16 consecutive cycles. A ratio of 0 blocks every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| temp_c | input | 8 | Die temperature in °C, unsigned |
| thr_c | input | 8 | Throttle threshold in °C |
| thr_ratio | input | 4 | Accepted cycles per 16 while throttled |
| ref_ack | input | 1 | Refresh acknowledge from the command scheduler |
| ref_req | output | 1 | Refresh request, held until acknowledged |
| ref_pending | output | 4 | Number of refreshes due and not yet acknowledged |
| ref_overflow | output | 1 | A refresh was lost because 8 were already pending |
| accept_allow | output | 1 | Per-cycle permission for the user interface to accept |

## Verification
The refresh period is measured as the gap between successive requests, using an immediate acknowledge, at a sequence of temperatures. The sequence steps across every breakpoint and both hysteresis edges in each direction, so a wrong breakpoint, a missing or one-sided hysteresis, and a wrong shift each show up as a distinct wrong gap. A band change injected mid-count separates reload-only update from immediate update. Withholding the acknowledge steps the pending count through saturation into overflow. Sweeping all 16 ratios, with the temperature one degree above and then equal to the threshold, pins down both the mask count and the strictness of the threshold compare.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [1:0] {
        RNG_NORM = 2'd0,
        RNG_WARM = 2'd1,
        RNG_HOT  = 2'd2
    } temp_rng_e;

    // Next temperature band, with hysteresis applied only on the way down.
    function automatic temp_rng_e rng_next(
        input temp_rng_e  cur,
        input logic [7:0] t,
        input logic [7:0] warm_c,
        input logic [7:0] hot_c,
        input logic [7:0] hyst_c
    );
        temp_rng_e nxt;
        nxt = cur;
        unique case (cur)
            RNG_NORM: begin
                if (t >= hot_c)       nxt = RNG_HOT;
                else if (t >= warm_c) nxt = RNG_WARM;
            end
            RNG_WARM: begin
                if (t >= hot_c)                nxt = RNG_HOT;
                else if (t < warm_c - hyst_c)  nxt = RNG_NORM;
            end
            RNG_HOT: begin
                if (t < warm_c - hyst_c)       nxt = RNG_NORM;
                else if (t < hot_c - hyst_c)   nxt = RNG_WARM;
            end
            default: nxt = RNG_NORM;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/temp_range_tracker.sv
module temp_range_tracker
    import rts_pkg::*;
#(
    parameter logic [7:0] WARM_C = 8'd85,
    parameter logic [7:0] HOT_C  = 8'd95,
    parameter logic [7:0] HYST_C = 8'd2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] temp_c,
    output temp_rng_e  rng
);

    always_ff @(posedge clk) begin
        if (rst) rng <= RNG_NORM;
        else     rng <= rng_next(rng, temp_c, WARM_C, HOT_C, HYST_C);
    end

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
    import rts_pkg::*;
#(
    parameter int unsigned NOM_CYC  = 3120,
    parameter int unsigned PEND_MAX = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  temp_rng_e                         rng,
    input  logic                              ref_ack,
    output logic                              ref_req,
    output logic [$clog2(PEND_MAX+1)-1:0]     ref_pending,
    output logic                              ref_overflow
);

    localparam int unsigned CW   = $clog2(NOM_CYC);
    localparam int unsigned PW   = $clog2(PEND_MAX + 1);
    localparam logic [CW-1:0] RL_NORM = CW'(NOM_CYC - 1);
    localparam logic [CW-1:0] RL_WARM = CW'((NOM_CYC >> 1) - 1);
    localparam logic [CW-1:0] RL_HOT  = CW'((NOM_CYC >> 2) - 1);
    localparam logic [PW-1:0] P_MAX   = PW'(PEND_MAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;
    logic [PW-1:0] pend;
    logic          tick;
    logic          take;
    logic          ovf;

    always_comb begin
        unique case (rng)
            RNG_WARM: reload = RL_WARM;
            RNG_HOT:  reload = RL_HOT;
            default:  reload = RL_NORM;
        endcase
    end

    assign tick = (cnt == '0);
    assign take = ref_ack && (pend != '0);

    // Band is sampled only at reload, so a running count is never retimed.
    always_ff @(posedge clk) begin
        if (rst)       cnt <= RL_NORM;
        else if (tick) cnt <= reload;
        else           cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ovf  <= 1'b0;
        end else begin
            unique case ({tick, take})
                2'b10: if (pend != P_MAX) pend <= pend + 1'b1;
                2'b01: pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
            if (take)                             ovf <= 1'b0;
            else if (tick && (pend == P_MAX))     ovf <= 1'b1;
        end
    end

    assign ref_req      = (pend != '0);
    assign ref_pending  = pend;
    assign ref_overflow = ovf;

endmodule

// File: rtl/throttle_mask.sv
module throttle_mask #(
    parameter int unsigned RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    temp_c,
    input  logic [7:0]    thr_c,
    input  logic [RW-1:0] thr_ratio,
    output logic          accept_allow
);

    logic [RW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    assign accept_allow = (temp_c <= thr_c) || (phase < thr_ratio);

endmodule

// File: rtl/refresh_throttle_sched.sv
module refresh_throttle_sched
    import rts_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 400,
    parameter int unsigned REF_NS   = 7800,
    parameter int unsigned PEND_MAX = 8,
    parameter logic [7:0]  WARM_C   = 8'd85,
    parameter logic [7:0]  HOT_C    = 8'd95,
    parameter logic [7:0]  HYST_C   = 8'd2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [7:0]                     temp_c,
    input  logic [7:0]                     thr_c,
    input  logic [3:0]                     thr_ratio,
    input  logic                           ref_ack,
    output logic                           ref_req,
    output logic [$clog2(PEND_MAX+1)-1:0]  ref_pending,
    output logic                           ref_overflow,
    output logic                           accept_allow
);

    localparam int unsigned NOM_CYC = (CLK_MHZ * REF_NS) / 1000;

    temp_rng_e rng;

    temp_range_tracker #(
        .WARM_C (WARM_C),
        .HOT_C  (HOT_C),
        .HYST_C (HYST_C)
    ) u_rng (
        .clk    (clk),
        .rst    (rst),
        .temp_c (temp_c),
        .rng    (rng)
    );

    refresh_timer #(
        .NOM_CYC  (NOM_CYC),
        .PEND_MAX (PEND_MAX)
    ) u_tmr (
        .clk          (clk),
        .rst          (rst),
        .rng          (rng),
        .ref_ack      (ref_ack),
        .ref_req      (ref_req),
        .ref_pending  (ref_pending),
        .ref_overflow (ref_overflow)
    );

    throttle_mask #(
        .RW (4)
    ) u_thr (
        .clk          (clk),
        .rst          (rst),
        .temp_c       (temp_c),
        .thr_c        (thr_c),
        .thr_ratio    (thr_ratio),
        .accept_allow (accept_allow)
    );

endmodule

// File: rtl/rts_checker.sv
module rts_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] temp_c,
    input logic [7:0] thr_c,
    input logic [3:0] thr_ratio,
    input logic       ref_ack,
    input logic       ref_req,
    input logic [3:0] ref_pending,
    input logic       ref_overflow,
    input logic       accept_allow
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!ref_req && ref_pending == 4'd0 && !ref_overflow));

    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_ack) |=> ref_req);

    a_r7_ack_never_grows: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_ack) |=> (ref_pending <= $past(ref_pending)));

    a_r8_pending_capped: assert property (@(posedge clk) disable iff (rst)
        ref_pending <= 4'd8);

    a_r9_overflow_at_cap: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_overflow) |-> (ref_pending == 4'd8 && $past(ref_pending) == 4'd8));

    a_r10_no_throttle: assert property (@(posedge clk) disable iff (rst)
        (temp_c <= thr_c) |-> accept_allow);

    a_r11_ratio_zero_blocks: assert property (@(posedge clk) disable iff (rst)
        (temp_c > thr_c && thr_ratio == 4'd0) |-> !accept_allow);

endmodule

bind refresh_throttle_sched rts_checker u_rts_chk (.*);

// File: tb/tb_refresh_throttle_sched.sv
module tb_refresh_throttle_sched;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 10;
    localparam int NOM        = (CLK_MHZ * 7800) / 1000;   // 78
    localparam int WARM       = NOM / 2;                   // 39
    localparam int HOT        = NOM / 4;                   // 19
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] temp_c = 8'd25;
    logic [7:0] thr_c = 8'd200;
    logic [3:0] thr_ratio = 4'd0;
    logic       ref_ack = 1'b0;
    logic       ref_req;
    logic [3:0] ref_pending;
    logic       ref_overflow;
    logic       accept_allow;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    refresh_throttle_sched #(.CLK_MHZ(CLK_MHZ)) dut (
        .clk          (clk),
        .rst          (rst),
        .temp_c       (temp_c),
        .thr_c        (thr_c),
        .thr_ratio    (thr_ratio),
        .ref_ack      (ref_ack),
        .ref_req      (ref_req),
        .ref_pending  (ref_pending),
        .ref_overflow (ref_overflow),
        .accept_allow (accept_allow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Gap between two successive requests, acknowledging each at once.
    task automatic gap_once(output int g);
        do begin
            @(negedge clk);
            ref_ack = ref_req;
        end while (!ref_req);
        g = 0;
        do begin
            @(negedge clk);
            g = g + 1;
            ref_ack = ref_req;
        end while (!ref_req);
    endtask

    task automatic drain();
        ref_ack = 1'b1;
        do @(negedge clk); while (ref_pending != 4'd0);
        ref_ack = 1'b0;
    endtask

    task automatic period_at(input int t, input int exp, input string req);
        int g;
        temp_c = 8'(t);
        drain();
        gap_once(g);
        gap_once(g);
        gap_once(g);
        ref_ack = 1'b0;
        chk(req, g, exp);
    endtask

    initial begin
        int g;
        int cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 req", int'(ref_req), 0);
        chk("R1 pending", int'(ref_pending), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 req after release", int'(ref_req), 0);
        chk("R1 overflow", int'(ref_overflow), 0);

        // R7: acknowledge with nothing pending has no effect
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        @(negedge clk);
        chk("R7 stray ack pending", int'(ref_pending), 0);
        chk("R7 stray ack req", int'(ref_req), 0);

        // R2..R5: periods across breakpoints and hysteresis edges
        period_at(25,  NOM,  "R2 25C");
        period_at(84,  NOM,  "R2 84C");
        period_at(85,  WARM, "R3 85C");
        period_at(84,  WARM, "R5 84C stays warm");
        period_at(83,  WARM, "R5 83C stays warm");
        period_at(82,  NOM,  "R5 82C leaves warm");
        period_at(95,  HOT,  "R4 95C");
        period_at(94,  HOT,  "R5 94C stays hot");
        period_at(93,  HOT,  "R5 93C stays hot");
        period_at(92,  WARM, "R5 92C leaves hot");
        period_at(94,  WARM, "R3 94C from warm");
        period_at(100, HOT,  "R4 100C");
        period_at(70,  NOM,  "R5 hot to nominal");
        period_at(0,   NOM,  "R2 0C");

        // R6: band change mid-count keeps the running interval
        drain();
        gap_once(g);
        do begin
            @(negedge clk);
            ref_ack = ref_req;
        end while (!ref_req);
        g = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            g = g + 1;
            ref_ack = ref_req;
        end
        temp_c = 8'd96;
        do begin
            @(negedge clk);
            g = g + 1;
            ref_ack = ref_req;
        end while (!ref_req);
        chk("R6 running count kept", g, NOM);
        g = 0;
        do begin
            @(negedge clk);
            g = g + 1;
            ref_ack = ref_req;
        end while (!ref_req);
        chk("R6 new interval after reload", g, HOT);
        ref_ack = 1'b0;

        // R8, R9: accumulate without acknowledge at the hot interval
        drain();
        do @(negedge clk); while (ref_pending != 4'd1);
        chk("R7 req with one pending", int'(ref_req), 1);
        for (int k = 1; k <= 8; k++) begin
            repeat (HOT - 1) @(negedge clk);
            chk("R9 no overflow before event", int'(ref_overflow), 0);
            @(negedge clk);
            chk("R8 pending count", int'(ref_pending), (k + 1 > 8) ? 8 : k + 1);
            chk("R9 overflow flag", int'(ref_overflow), (k == 8) ? 1 : 0);
        end
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        chk("R7 ack decrements", int'(ref_pending), 7);
        chk("R9 ack clears overflow", int'(ref_overflow), 0);
        repeat (3) @(negedge clk);
        chk("R7 req held", int'(ref_req), 1);
        chk("R7 pending held", int'(ref_pending), 7);

        // R10, R11: throttle mask sweep
        temp_c = 8'd61;
        thr_c  = 8'd60;
        for (int r = 0; r < 16; r++) begin
            thr_ratio = 4'(r);
            cnt = 0;
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                if (accept_allow) cnt = cnt + 1;
            end
            chk("R11 allowed per 16", cnt, r);
            cnt = 0;
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                if (accept_allow) cnt = cnt + 1;
            end
            chk("R11 next window", cnt, r);
        end
        temp_c = 8'd60;
        for (int r = 0; r < 16; r += 5) begin
            thr_ratio = 4'(r);
            cnt = 0;
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                if (accept_allow) cnt = cnt + 1;
            end
            chk("R10 at threshold no throttle", cnt, 16);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule